// File: doc/BRIEF.md
# Bitplane Pixel Index and Palette Bypass Stage

This block is the per-pixel back end of a planar display controller. For each pixel it receives up to eight bitplane bits, the palette index of a sprite pixel and the mode controls. From these it works out which planes really take part in the pixel and builds a colour index. When palette bypass is off, it hands that index to an external palette lookup. When bypass is on, it strips the control planes of the special modes and drives the remaining value as a grayscale RGB triple.

Alongside the pixel path, a purely combinational decoder turns the programmed plane count into two counts. The fetch count tells the memory side how many planes to read. The display count tells the pixel side how many planes to honour. The two differ for illegal programmed counts, which lets software enable a display mode wider than the data actually fetched.

The bitplane bits are numbered 0 to 7, with bit 0 being the first plane. Hold-and-modify is abbreviated HAM below, and extra-half-brite is abbreviated EHB.

Top module: `pixel_index_stage`

## Requirements
- R1: With `wide_mode`=0 and `plane_cnt` from 0 to 6, `fetch_cnt` and `disp_cnt` both equal `plane_cnt` (combinational).
- R2: With `wide_mode`=0, `plane_cnt`=7 gives `fetch_cnt`=4 and `disp_cnt`=6; `plane_cnt` from 8 to 15 gives 6 for both.
- R3: With `wide_mode`=1, `plane_cnt` from 0 to 8 passes through to both outputs; any count above 8 gives 8 for both.
- R4: Any plane bit whose number is equal to or above `disp_cnt` contributes zero to the index and to the bypass value.
- R5: HAM applies when `ham_en`=1 and either `disp_cnt`=6, or `disp_cnt`=8 with `wide_mode`=1. EHB applies only when `ehb_en`=1, `disp_cnt`=6 and HAM does not apply. When `ham_en` and `ehb_en` are both set, HAM therefore takes precedence over EHB.
- R6: In bypass with 6-plane HAM, bits 4 and 5 are removed, so the value lies in 0 to 15.
- R7: In bypass with 8-plane HAM, bits 0 and 1 are forced to zero.
- R8: In bypass with EHB, bit 5 is removed, so the value lies in 0 to 31.
- R9: In bypass, `out_r`, `out_g` and `out_b` all equal the bypass value, and `out_idx` is 0.
- R10: When `spr_hit`=1, the raw `spr_idx` is used unmasked, both as the index and as the bypass value.
- R11: When bypass is off, a valid input pixel produces `out_valid`=1 and its index on `out_idx` one clock later, with all RGB outputs 0.
- R12: When `pix_valid`=0, the next cycle has `out_valid`=0 and all data outputs 0. While reset is held, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel present |
| plane_bits | input | 8 | Bitplane bits of the pixel, bit 0 = first plane |
| spr_hit | input | 1 | Visible sprite pixel |
| spr_idx | input | 8 | Sprite palette index |
| plane_cnt | input | 4 | Programmed plane count |
| ham_en | input | 1 | Hold-and-modify enable |
| ehb_en | input | 1 | Half-brite enable |
| bypass | input | 1 | Palette bypass |
| wide_mode | input | 1 | Wide (8-plane) chipset mode |
| fetch_cnt | output | 4 | Planes the fetch side must read |
| disp_cnt | output | 4 | Planes the display side honours |
| out_valid | output | 1 | Registered pixel valid |
| out_idx | output | 8 | Palette index (bypass off) |
| out_r | output | 8 | Red, grayscale in bypass |
| out_g | output | 8 | Green, grayscale in bypass |
| out_b | output | 8 | Blue, grayscale in bypass |

## Verification
Random plane bits are applied under every plane count in both chipset modes, which separates the fetch decode from the display decode and catches planes leaking past the display count. Directed pixels with all plane bits set are run in bypass under 6-plane HAM, 8-plane HAM and EHB. Because every bit is set, each stripped control plane shows up as a distinct missing value. Running with `ham_en` and `ehb_en` both set at a count of 6 confirms that HAM wins. Sprite pixels carrying indices with high bits set, while the display count is small, show that the sprite index bypasses plane masking.

// File: rtl/pixel_index_stage.sv
module pixel_index_stage #(
  parameter int PLANES = 8,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PLANES-1:0] plane_bits,
  input  logic              spr_hit,
  input  logic [PLANES-1:0] spr_idx,
  input  logic [CW-1:0]     plane_cnt,
  input  logic              ham_en,
  input  logic              ehb_en,
  input  logic              bypass,
  input  logic              wide_mode,
  output logic [CW-1:0]     fetch_cnt,
  output logic [CW-1:0]     disp_cnt,
  output logic              out_valid,
  output logic [PLANES-1:0] out_idx,
  output logic [PLANES-1:0] out_r,
  output logic [PLANES-1:0] out_g,
  output logic [PLANES-1:0] out_b
);
  localparam int NARROW_MAX = PLANES - 2;

  always_comb begin
    if (wide_mode) begin
      if (int'(plane_cnt) > PLANES) begin
        fetch_cnt = CW'(PLANES);
        disp_cnt  = CW'(PLANES);
      end else begin
        fetch_cnt = plane_cnt;
        disp_cnt  = plane_cnt;
      end
    end else if (int'(plane_cnt) <= NARROW_MAX) begin
      fetch_cnt = plane_cnt;
      disp_cnt  = plane_cnt;
    end else if (int'(plane_cnt) == NARROW_MAX + 1) begin
      fetch_cnt = CW'(4);
      disp_cnt  = CW'(NARROW_MAX);
    end else begin
      fetch_cnt = CW'(NARROW_MAX);
      disp_cnt  = CW'(NARROW_MAX);
    end
  end

  logic [PLANES-1:0] masked;
  always_comb
    for (int i = 0; i < PLANES; i++)
      masked[i] = plane_bits[i] && (i < int'(disp_cnt));

  wire ham6 = ham_en && (int'(disp_cnt) == 6);
  wire ham8 = ham_en && wide_mode && (int'(disp_cnt) == 8);
  wire ehb  = ehb_en && (int'(disp_cnt) == 6) && !ham6;

  logic [PLANES-1:0] strip;
  always_comb begin
    strip = masked;
    if (ham6)      strip = masked & 8'h0F;
    else if (ham8) strip = masked & 8'hFC;
    else if (ehb)  strip = masked & 8'h1F;
  end

  wire [PLANES-1:0] idx_n  = spr_hit ? spr_idx : masked;
  wire [PLANES-1:0] gray_n = spr_hit ? spr_idx : strip;

  always_ff @(posedge clk) begin
    if (!rst_n || !pix_valid) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= 1'b1;
      out_idx   <= bypass ? '0 : idx_n;
      out_r     <= bypass ? gray_n : '0;
      out_g     <= bypass ? gray_n : '0;
      out_b     <= bypass ? gray_n : '0;
    end
  end
endmodule

module pixel_index_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic [7:0] plane_bits,
  input logic       spr_hit,
  input logic [3:0] plane_cnt,
  input logic       ham_en,
  input logic       ehb_en,
  input logic       bypass,
  input logic       wide_mode,
  input logic [3:0] fetch_cnt,
  input logic [3:0] disp_cnt,
  input logic       out_valid,
  input logic [7:0] out_idx,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b
);
  a_r2_seven_split: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && plane_cnt == 4'd7) |-> (fetch_cnt == 4'd4 && disp_cnt == 4'd6));
  a_r1_narrow_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && plane_cnt <= 4'd6) |-> (fetch_cnt == plane_cnt && disp_cnt == plane_cnt));
  a_r9_gray: assert property (@(posedge clk) disable iff (!rst_n)
    (out_r == out_g && out_g == out_b));
  a_r11_rgb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !bypass) |=> (out_valid && out_r == 8'd0));
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && out_idx == 8'd0 && out_r == 8'd0));
  a_r6_ham6_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bypass && ham_en && !spr_hit && disp_cnt == 4'd6) |=> (out_r[7:4] == 4'd0));
  a_r8_ehb_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bypass && ehb_en && !ham_en && !spr_hit && disp_cnt == 4'd6) |=> (out_r[7:5] == 3'd0));
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !bypass && !spr_hit && disp_cnt == 4'd4) |=> (out_idx[7:4] == 4'd0));
endmodule

bind pixel_index_stage pixel_index_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .plane_bits(plane_bits),
  .spr_hit(spr_hit), .plane_cnt(plane_cnt), .ham_en(ham_en), .ehb_en(ehb_en),
  .bypass(bypass), .wide_mode(wide_mode), .fetch_cnt(fetch_cnt), .disp_cnt(disp_cnt),
  .out_valid(out_valid), .out_idx(out_idx), .out_r(out_r), .out_g(out_g), .out_b(out_b));

// File: tb/test_pixel_index_stage.sv
module test_pixel_index_stage;
  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, spr_hit = 0, ham_en = 0, ehb_en = 0, bypass = 0, wide_mode = 0;
  logic [7:0] plane_bits = 0, spr_idx = 0;
  logic [3:0] plane_cnt = 0;
  logic [3:0] fetch_cnt, disp_cnt;
  logic out_valid;
  logic [7:0] out_idx, out_r, out_g, out_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pixel_index_stage i_pixel_index_stage (.*);

  function automatic void model_cnt(input logic w, input int c, output int f, output int d);
    if (w) begin f = (c > 8) ? 8 : c; d = f; end
    else if (c <= 6) begin f = c; d = c; end
    else if (c == 7) begin f = 4; d = 6; end
    else begin f = 6; d = 6; end
  endfunction

  function automatic logic [7:0] model_pix(input logic w, input int c, input logic [7:0] pb,
      input logic sh, input logic [7:0] si, input logic h, input logic e, input logic byp);
    int f, d;
    logic [7:0] m, v;
    model_cnt(w, c, f, d);
    m = (d >= 8) ? pb : (pb & 8'((1 << d) - 1));
    if (sh) return si;
    if (!byp) return m;
    v = m;
    if (h && d == 6) v[5:4] = 2'b00;
    else if (h && w && d == 8) v[1:0] = 2'b00;
    else if (e && d == 6) v[5] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic v, input logic w, input int c, input logic [7:0] pb,
      input logic sh, input logic [7:0] si, input logic h, input logic e, input logic byp);
    int f, d;
    logic [7:0] ev;
    @(negedge clk);
    pix_valid = v; wide_mode = w; plane_cnt = 4'(c); plane_bits = pb;
    spr_hit = sh; spr_idx = si; ham_en = h; ehb_en = e; bypass = byp;
    model_cnt(w, c, f, d);
    ev = model_pix(w, c, pb, sh, si, h, e, byp);
    #1;
    chk({req, " fetch"}, int'(fetch_cnt), f);
    chk({req, " disp"}, int'(disp_cnt), d);
    @(posedge clk); #1;
    chk({req, " valid"}, int'(out_valid), int'(v));
    chk({req, " idx"}, int'(out_idx), (v && !byp) ? int'(ev) : 0);
    chk({req, " r"}, int'(out_r), (v && byp) ? int'(ev) : 0);
    chk({req, " g"}, int'(out_g), (v && byp) ? int'(ev) : 0);
    chk({req, " b"}, int'(out_b), (v && byp) ? int'(ev) : 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed);
    pix_valid = 1; plane_bits = 8'hFF; bypass = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset valid", int'(out_valid), 0);
    chk("R12 reset r", int'(out_r), 0);
    chk("R12 reset idx", int'(out_idx), 0);
    rst_n = 1;

    for (int c = 0; c < 16; c++) begin
      apply(c <= 6 ? "R1 narrow" : "R2 narrow", 1, 0, c, 8'hFF, 0, 0, 0, 0, 0);
      apply("R3 wide", 1, 1, c, 8'hFF, 0, 0, 0, 0, 0);
    end
    apply("R4 upper planes", 1, 0, 3, 8'hFF, 0, 0, 0, 0, 0);
    apply("R6 ham6 bypass", 1, 0, 6, 8'hFF, 0, 0, 1, 0, 1);
    apply("R5 ham over ehb", 1, 0, 7, 8'hFF, 0, 0, 1, 1, 1);
    apply("R7 ham8 bypass", 1, 1, 8, 8'hFF, 0, 0, 1, 0, 1);
    apply("R8 ehb bypass", 1, 0, 6, 8'hFF, 0, 0, 0, 1, 1);
    apply("R8 ehb no ham", 1, 1, 6, 8'h3F, 0, 0, 0, 1, 1);
    apply("R9 gray plain", 1, 1, 8, 8'hA5, 0, 0, 0, 0, 1);
    apply("R10 sprite bypass", 1, 0, 2, 8'h00, 1, 8'hF3, 1, 0, 1);
    apply("R10 sprite index", 1, 0, 1, 8'hFF, 1, 8'hC7, 0, 0, 0);
    apply("R11 index path", 1, 0, 5, 8'h15, 0, 0, 0, 0, 0);
    apply("R12 idle", 0, 1, 8, 8'hFF, 0, 0, 0, 0, 1);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      apply("R4 random", r[0] | r[1], r[2], int'(r[6:3]), 8'($urandom), r[7] & r[8],
            8'($urandom), r[9], r[10], r[11]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule